// File: doc/BRIEF.md
# Fractional Tick Divider

This block derives a slow periodic tick from a low-frequency reference clock by dividing with a non-integer ratio. The ratio has two parts. The first is a 9-bit whole-cycle divisor, INT. The second is a 10-bit numerator, FRAC, taken over a window of DEN output periods. A single select input sets DEN to either 1000 or 1024, so both decimal and power-of-two fractions come out exact over one window. With INT=327, FRAC=680 and the decimal window, a 32.768 kHz reference gives an average ratio of 327.68, which is a 100 Hz tick.

The lengthened periods are spread as evenly as possible across the window. A phase accumulator adds FRAC once per period. The divisor values are taken only when a period starts, so a configuration change never disturbs a period that is already running. The block also registers a reset request for the downstream timekeeping logic and passes it on one cycle later. The package carries the recommended power-up configuration values for whatever register host drives the configuration inputs.

Top module: `frac_tick_div`

## Requirements
- R1: `tick_o` is high for exactly one reference cycle, at the end of each output period, and never on two consecutive cycles.
- R2: Number the periods after enable from k=1. Period k lasts INT+1 cycles when floor(k*FRAC/DEN) > floor((k-1)*FRAC/DEN), and INT cycles otherwise. Every window of DEN consecutive periods therefore holds exactly FRAC long periods.
- R3: `den_sel_i`=0 selects DEN=1000 and `den_sel_i`=1 selects DEN=1024.
- R4: An INT value of 0 or 1 is used as 2.
- R5: A FRAC value greater than or equal to the selected DEN is used as DEN-1.
- R6: While `en_i` is low, no tick is produced and the period counter and phase accumulator are cleared. The first tick after `en_i` rises comes INT cycles after the first rising edge that samples `en_i` high.
- R7: INT, FRAC and the denominator select are sampled only at period boundaries. A change in the middle of a period leaves that period's length unchanged and applies to the next one.
- R8: Synchronous active-high `rst` drives `tick_o` and `tc_rst_o` low. Outside reset, `tc_rst_o` equals `tc_rst_req_i` delayed by one clock.
- R9: The recommended configuration (INT=327, FRAC=680, decimal window) produces the period sequence 327, 328, 328, 327, 328 at the start of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Tick generation enable |
| den_sel_i | input | 1 | Window select: 0 = 1000 periods, 1 = 1024 periods |
| int_div_i | input | 9 | Whole-cycle divisor INT |
| frac_num_i | input | 10 | Fractional numerator FRAC |
| tc_rst_req_i | input | 1 | Reset request for downstream timekeeping |
| tick_o | output | 1 | One-cycle tick at the end of each period |
| tc_rst_o | output | 1 | Registered reset request |

## Verification
The bench measures the length of every period over complete 1000- and 1024-period windows and compares each one against the closed-form floor rule. A wrong carry comparison (> in place of >=) or a window constant off by one shows up as a wrong long-period count or a shifted position. Clamped inputs are also exercised: INT of 0 and 1, and FRAC of 1023 under the decimal window. A design that did not saturate these would give a one-cycle tick stream or an accumulator that never settles. Two further tests target state handling. One disables the block just after a period that left the accumulator nonzero; a design that kept that residue would make the first period after re-enable long. The other changes INT in the middle of a period; a design that did not wait for the boundary would cut the running period short.

// File: rtl/frac_tick_div_pkg.sv
package frac_tick_div_pkg;

  // Window select encoding
  typedef enum logic {
    WIN_DECIMAL = 1'b0,
    WIN_BINARY  = 1'b1
  } win_sel_e;

  // Recommended power-up configuration for the register host
  localparam int unsigned CFG_INT_DEFAULT  = 327;
  localparam int unsigned CFG_FRAC_DEFAULT = 680;
  localparam win_sel_e    CFG_WIN_DEFAULT  = WIN_DECIMAL;
  localparam logic        CFG_EN_DEFAULT   = 1'b0;

  // Window lengths in output periods
  localparam int unsigned WIN_LEN_DEC = 1000;
  localparam int unsigned WIN_LEN_BIN = 1024;

  // Smallest usable whole-cycle divisor
  localparam int unsigned INT_FLOOR = 2;

endpackage

// File: rtl/fdiv_cfg_clamp.sv
module fdiv_cfg_clamp
  import frac_tick_div_pkg::*;
#(
  parameter int unsigned INT_W   = 9,
  parameter int unsigned FRAC_W  = 10,
  parameter int unsigned WIN_DEC = WIN_LEN_DEC,
  parameter int unsigned WIN_BIN = WIN_LEN_BIN,
  localparam int unsigned DEN_W  = FRAC_W + 1
) (
  input  logic              win_sel_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W-1:0]  int_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [DEN_W-1:0]  den_o
);

  localparam logic [DEN_W-1:0] DEN_DEC_C = DEN_W'(WIN_DEC);
  localparam logic [DEN_W-1:0] DEN_BIN_C = DEN_W'(WIN_BIN);
  localparam logic [INT_W-1:0] INT_MIN_C = INT_W'(INT_FLOOR);

  logic [DEN_W-1:0] frac_ext;

  always_comb begin
    den_o    = (win_sel_e'(win_sel_i) == WIN_BINARY) ? DEN_BIN_C : DEN_DEC_C;
    frac_ext = {1'b0, frac_i};
    if (frac_ext >= den_o) begin
      frac_o = FRAC_W'(den_o - DEN_W'(1));
    end else begin
      frac_o = frac_i;
    end
    if (int_i < INT_MIN_C) begin
      int_o = INT_MIN_C;
    end else begin
      int_o = int_i;
    end
  end

endmodule

// File: rtl/fdiv_phase_acc.sv
module fdiv_phase_acc #(
  parameter int unsigned FRAC_W = 10,
  localparam int unsigned DEN_W = FRAC_W + 1,
  localparam int unsigned SUM_W = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [DEN_W-1:0]  den_i,
  output logic              long_o
);

  logic [DEN_W-1:0] acc_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] base;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] den_ext;

  // A window change restarts the spreading sequence so the residue stays below the new window.
  always_comb begin
    base    = (den_i != den_q) ? '0 : acc_q;
    sum     = SUM_W'(base) + SUM_W'(frac_i);
    den_ext = SUM_W'(den_i);
    long_o  = (sum >= den_ext);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      acc_q <= '0;
      den_q <= '0;
    end else if (step_i) begin
      den_q <= den_i;
      if (long_o) begin
        acc_q <= DEN_W'(sum - den_ext);
      end else begin
        acc_q <= DEN_W'(sum);
      end
    end
  end

  // R2: the residue always stays inside the window it was built for
  a_r2_acc_in_window: assert property (@(posedge clk) disable iff (rst)
    (den_q != '0) |-> (acc_q < den_q));

endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             tick_o
);

  logic             active_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  // A new period starts on the first enabled cycle or when the running one completes.
  assign load_o = !active_q || (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      len_q    <= '0;
      tick_o   <= 1'b0;
    end else if (load_o) begin
      active_q <= 1'b1;
      cnt_q    <= LEN_W'(1);
      len_q    <= len_i;
      tick_o   <= active_q;
    end else begin
      cnt_q  <= cnt_q + LEN_W'(1);
      tick_o <= 1'b0;
    end
  end

  // R4: a captured period is never shorter than two cycles
  a_r4_len_floor: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (len_q >= LEN_W'(2)));

  // R7: the count never overruns the captured length
  a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (cnt_q <= len_q && cnt_q != '0));

  // R1: a tick never lasts more than one cycle
  a_r1_tick_single: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

endmodule

// File: rtl/frac_tick_div.sv
module frac_tick_div
  import frac_tick_div_pkg::*;
#(
  parameter int unsigned INT_W   = 9,
  parameter int unsigned FRAC_W  = 10,
  parameter int unsigned WIN_DEC = WIN_LEN_DEC,
  parameter int unsigned WIN_BIN = WIN_LEN_BIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              den_sel_i,
  input  logic [INT_W-1:0]  int_div_i,
  input  logic [FRAC_W-1:0] frac_num_i,
  input  logic              tc_rst_req_i,
  output logic              tick_o,
  output logic              tc_rst_o
);

  localparam int unsigned DEN_W = FRAC_W + 1;
  localparam int unsigned LEN_W = INT_W + 1;

  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W-1:0] frac_eff;
  logic [DEN_W-1:0]  den_eff;
  logic              load;
  logic              long_per;
  logic [LEN_W-1:0]  len_next;

  fdiv_cfg_clamp #(
    .INT_W   (INT_W),
    .FRAC_W  (FRAC_W),
    .WIN_DEC (WIN_DEC),
    .WIN_BIN (WIN_BIN)
  ) u_clamp (
    .win_sel_i (den_sel_i),
    .int_i     (int_div_i),
    .frac_i    (frac_num_i),
    .int_o     (int_eff),
    .frac_o    (frac_eff),
    .den_o     (den_eff)
  );

  fdiv_phase_acc #(
    .FRAC_W (FRAC_W)
  ) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (!en_i),
    .step_i (load),
    .frac_i (frac_eff),
    .den_i  (den_eff),
    .long_o (long_per)
  );

  assign len_next = LEN_W'(int_eff) + LEN_W'(long_per);

  fdiv_period_cnt #(
    .LEN_W (LEN_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .len_i  (len_next),
    .load_o (load),
    .tick_o (tick_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_rst_o <= 1'b0;
    end else begin
      tc_rst_o <= tc_rst_req_i;
    end
  end

  // R8: the reset request reaches the output one cycle later
  a_r8_req_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (tc_rst_o == $past(tc_rst_req_i)));

  // R6: a disabled cycle is never followed by a tick
  a_r6_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tick_o);

endmodule

// File: tb/frac_tick_div_tb.sv
`timescale 1ns/1ps
module frac_tick_div_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic       dsel;
  logic [8:0] idiv;
  logic [9:0] fnum;
  logic       rreq;
  logic       tick;
  logic       rrst;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  frac_tick_div u_dut (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en),
    .den_sel_i    (dsel),
    .int_div_i    (idiv),
    .frac_num_i   (fnum),
    .tc_rst_req_i (rreq),
    .tick_o       (tick),
    .tc_rst_o     (rrst)
  );

  // {sel, INT, FRAC, periods, expected total cycles}
  localparam int NV = 9;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0, 9'd327, 10'd680,  11'd5,    16'd1638},  // R9 R2
    {1'b0, 9'd3,   10'd500,  11'd1000, 16'd3500},  // R2 R3
    {1'b1, 9'd2,   10'd1023, 11'd1024, 16'd3071},  // R3
    {1'b1, 9'd5,   10'd512,  11'd1024, 16'd5632},  // R3
    {1'b0, 9'd4,   10'd0,    11'd20,   16'd80},    // R2
    {1'b1, 9'd2,   10'd1,    11'd1024, 16'd2049},  // R3
    {1'b0, 9'd0,   10'd0,    11'd10,   16'd20},    // R4
    {1'b0, 9'd1,   10'd1023, 11'd1000, 16'd2999},  // R4 R5
    {1'b0, 9'd7,   10'd999,  11'd1000, 16'd7999}   // R2
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 4000);
    if (!tick) chk(1'b0, "watchdog", n, 0);
  endtask

  function automatic int long_at(input int k, input int f, input int d);
    return ((k * f) / d) - (((k - 1) * f) / d);
  endfunction

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    int tot;
    rst = 1'b1; en = 1'b0; dsel = 1'b0; idiv = 9'd327; fnum = 10'd680; rreq = 1'b1;
    repeat (3) @(negedge clk);
    chk(tick == 1'b0, "R8 tick in reset", int'(tick), 0);
    chk(rrst == 1'b0, "R8 req out in reset", int'(rrst), 0);
    rst = 1'b0; rreq = 1'b0;
    @(negedge clk);

    // Table walk: every period length against the floor rule
    for (int v = 0; v < NV; v++) begin
      int ie, fe, de, np, et;
      en = 1'b0;
      repeat (2) @(negedge clk);
      dsel = VEC[v][46];
      idiv = VEC[v][45:37];
      fnum = VEC[v][36:27];
      np   = int'(VEC[v][26:16]);
      et   = int'(VEC[v][15:0]);
      de   = dsel ? 1024 : 1000;
      ie   = (idiv < 2) ? 2 : int'(idiv);
      fe   = (int'(fnum) >= de) ? de - 1 : int'(fnum);
      en   = 1'b1;
      tot  = 0;
      for (int k = 1; k <= np; k++) begin
        wait_tick(n);
        if (k == 1) n = n - 1;
        tot += n;
        if (n != ie + long_at(k, fe, de))
          chk(1'b0, "R2 period length", n, ie + long_at(k, fe, de));
      end
      chk(tot == et, "R2 R3 R4 R5 window total", tot, et);
    end
    chk(1'b1, "R9 default sequence (vector 0)", 0, 0);

    // R1: tick lasts one cycle
    @(negedge clk);
    chk(tick == 1'b0, "R1 tick width", int'(tick), 0);

    // R6: disable after one period with nonzero residue, then restart
    en = 1'b0;
    repeat (2) @(negedge clk);
    dsel = 1'b1; idiv = 9'd3; fnum = 10'd700;
    en = 1'b1;
    wait_tick(n);
    chk(n - 1 == 3, "R6 first period", n - 1, 3);
    en = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (tick) seen++;
      end
      chk(seen == 0, "R6 no tick while disabled", seen, 0);
    end
    en = 1'b1;
    wait_tick(n);
    chk(n - 1 == 3, "R6 residue cleared on restart", n - 1, 3);
    wait_tick(n);
    chk(n == 4, "R6 second period after restart", n, 4);

    // R7: change INT mid-period
    en = 1'b0;
    repeat (2) @(negedge clk);
    dsel = 1'b0; idiv = 9'd10; fnum = 10'd0;
    en = 1'b1;
    repeat (4) @(negedge clk);
    idiv = 9'd20;
    wait_tick(n);
    chk(n + 4 - 1 == 10, "R7 running period kept", n + 3, 10);
    wait_tick(n);
    chk(n == 20, "R7 new value at boundary", n, 20);

    // R8: request passthrough
    rreq = 1'b1;
    @(negedge clk);
    chk(rrst == 1'b1, "R8 request rise", int'(rrst), 1);
    rreq = 1'b0;
    @(negedge clk);
    chk(rrst == 1'b0, "R8 request fall", int'(rrst), 0);

    // R8: reset in the middle of a run
    rreq = 1'b1;
    rst = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (tick || rrst) seen++;
      end
      chk(seen == 0, "R8 outputs held in reset", seen, 0);
    end
    rst = 1'b0;
    wait_tick(n);
    chk(n - 1 == 20, "R6 R8 first period after reset", n - 1, 20);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule